// File: doc/BRIEF.md
# Sample Frame Timing Generator with Phase Tracking

This block keeps the internal sample-timing counter of a serial audio port. The counter steps once per master clock and wraps once per sample frame. With the master role selected, the block divides the master clock down and drives the frame (left/right) clock and the bit clock from that counter. With the slave role selected, the block drives no clocks. It follows an external frame clock instead. The external clock passes through a two-flop synchronizer, and every rising edge of it is compared against the internal count.

The phase error is the internal count at the moment an external rising edge is seen, folded into a signed range around zero. A small error, up to one sixteenth of a frame either way, is tolerated and leaves the timing unchanged. Jitter and small drift therefore do not disturb the downstream data path. A larger error forces the counter back onto the edge and raises a one-cycle `resync` pulse. After reset in the slave role, the counter waits at zero until the first external edge and starts aligned to it.

Top module: `frameClockGen`

## Requirements
- R1: While `rstN` is low, `frameCount` is 0 and `lrclkOut`, `bitclkOut` and `resync` are all low.
- R2: In master role (`masterMode`=1), `frameCount` reads n mod 768 just after the n-th rising `mclk` edge following reset release.
- R3: In master role, `lrclkOut` is high exactly when `frameCount` < 384. `bitclkOut` is high exactly when `frameCount` mod 12 >= 6, which gives 64 bit periods per frame.
- R4: In master role, edges on `extLrclk` have no effect: the count keeps its R2 sequence and `resync` stays low.
- R5: In slave role (`masterMode`=0), `lrclkOut` and `bitclkOut` stay low. After reset, `frameCount` holds at 0 until the first external rising edge.
- R6: In slave role, an external rising edge first sampled high at `mclk` edge k is acted on at edge k+2. The phase error is the `frameCount` value seen just before edge k+2, read as signed: values of 384 and above count as value minus 768. On the first edge after reset the error is 0, and `frameCount` reads 1 after edge k+2.
- R7: In slave role, if the phase error lies within -48..+48 inclusive, the counter simply advances and `resync` stays low.
- R8: In slave role, if the phase error lies outside -48..+48, `frameCount` loads 1 at edge k+2 and `resync` is high for that one cycle only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk | input | 1 | Master clock, 768 times the sample rate |
| rstN | input | 1 | Active-low asynchronous system reset |
| masterMode | input | 1 | 1 selects master role, 0 selects slave role |
| extLrclk | input | 1 | External frame clock, asynchronous to mclk |
| lrclkOut | output | 1 | Generated frame clock (master role only) |
| bitclkOut | output | 1 | Generated bit clock (master role only) |
| frameCount | output | 10 | Position within the current frame, 0..767 |
| resync | output | 1 | One-cycle pulse on each realignment |

## Verification
The assertions assume that `masterMode` only changes while `rstN` is low, and that each external frame edge stays high and low for at least three master clocks so the synchronizer sees it. The stimulus selects the role before each reset release and never changes it afterwards. It drives `extLrclk` on falling `mclk` edges with half-frame high times, and places edge spacings at exactly ±48 and ±49 cycles of error to exercise both sides of the tolerance window.

// File: rtl/fcgPkg.sv
package fcgPkg;

  // Strobes passed from the control to the datapath each cycle.
  typedef struct packed {
    logic genEnable; // drive the generated clocks
    logic align;     // load the counter to the post-edge position
    logic advance;   // step the counter by one
  } fcgStrobes_t;

endpackage

// File: rtl/fcgControl.sv
module fcgControl #(
  parameter int FRAME_LEN   = 768,
  parameter int TOL_DIV     = 16,
  parameter int SYNC_STAGES = 2,
  localparam int CNT_W = $clog2(FRAME_LEN)
) (
  input  logic                 mclk,
  input  logic                 rstN,
  input  logic                 masterMode,
  input  logic                 extLrclk,
  input  logic [CNT_W-1:0]     countIn,
  output fcgPkg::fcgStrobes_t  strobes,
  output logic                 resyncQ
);
  localparam int MAG_W = CNT_W + 1;
  localparam logic [MAG_W-1:0] FRAME_V = MAG_W'(FRAME_LEN);
  localparam logic [MAG_W-1:0] HALF_V  = MAG_W'(FRAME_LEN / 2);
  localparam logic [MAG_W-1:0] TOL_V   = MAG_W'(FRAME_LEN / TOL_DIV);

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   prevQ;
  logic                   runQ;
  logic                   startedQ;

  // synchronizer chain for the asynchronous frame clock
  always_ff @(posedge mclk or negedge rstN) begin
    if (!rstN) syncQ[0] <= 1'b0;
    else       syncQ[0] <= extLrclk;
  end

  genvar g;
  generate
    for (g = 1; g < SYNC_STAGES; g++) begin : gSync
      always_ff @(posedge mclk or negedge rstN) begin
        if (!rstN) syncQ[g] <= 1'b0;
        else       syncQ[g] <= syncQ[g-1];
      end
    end
  endgenerate

  always_ff @(posedge mclk or negedge rstN) begin
    if (!rstN) prevQ <= 1'b0;
    else       prevQ <= syncQ[SYNC_STAGES-1];
  end

  logic extRise;
  assign extRise = syncQ[SYNC_STAGES-1] & ~prevQ;

  // folded phase error magnitude
  logic [MAG_W-1:0] countWide;
  logic [MAG_W-1:0] errMag;
  logic             outsideWin;

  assign countWide  = {1'b0, countIn};
  assign errMag     = (countWide < HALF_V) ? countWide : (FRAME_V - countWide);
  assign outsideWin = errMag > TOL_V;

  logic slaveRise;
  assign slaveRise = ~masterMode & extRise;

  always_comb begin
    strobes.genEnable = masterMode & runQ;
    if (masterMode) begin
      strobes.align   = 1'b0;
      strobes.advance = 1'b1;
    end else if (!startedQ) begin
      strobes.align   = slaveRise;
      strobes.advance = 1'b0;
    end else begin
      strobes.align   = slaveRise & outsideWin;
      strobes.advance = ~(slaveRise & outsideWin);
    end
  end

  always_ff @(posedge mclk or negedge rstN) begin
    if (!rstN) begin
      runQ     <= 1'b0;
      startedQ <= 1'b0;
      resyncQ  <= 1'b0;
    end else begin
      runQ     <= 1'b1;
      startedQ <= startedQ | slaveRise;
      resyncQ  <= startedQ & slaveRise & outsideWin;
    end
  end

endmodule

// File: rtl/fcgDatapath.sv
module fcgDatapath #(
  parameter int FRAME_LEN    = 768,
  parameter int MCLK_PER_BIT = 12,
  localparam int CNT_W = $clog2(FRAME_LEN),
  localparam int BIT_W = (MCLK_PER_BIT > 1) ? $clog2(MCLK_PER_BIT) : 1
) (
  input  logic                mclk,
  input  logic                rstN,
  input  fcgPkg::fcgStrobes_t strobes,
  output logic [CNT_W-1:0]    countQ,
  output logic                lrclkOut,
  output logic                bitclkOut
);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(FRAME_LEN - 1);
  localparam logic [CNT_W-1:0] HALF_CNT = CNT_W'(FRAME_LEN / 2);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(MCLK_PER_BIT - 1);
  localparam logic [BIT_W-1:0] HALF_BIT = BIT_W'(MCLK_PER_BIT / 2);
  localparam logic [BIT_W-1:0] ONE_BIT  = BIT_W'((MCLK_PER_BIT > 1) ? 1 : 0);

  logic [BIT_W-1:0] bitPhaseQ;

  always_ff @(posedge mclk or negedge rstN) begin
    if (!rstN) begin
      countQ    <= '0;
      bitPhaseQ <= '0;
    end else if (strobes.align) begin
      countQ    <= CNT_W'(1);
      bitPhaseQ <= ONE_BIT;
    end else if (strobes.advance) begin
      countQ    <= (countQ == LAST_CNT) ? '0 : countQ + CNT_W'(1);
      bitPhaseQ <= (bitPhaseQ == LAST_BIT) ? '0 : bitPhaseQ + BIT_W'(1);
    end
  end

  assign lrclkOut  = strobes.genEnable & (countQ < HALF_CNT);
  assign bitclkOut = strobes.genEnable & (bitPhaseQ >= HALF_BIT);

endmodule

// File: rtl/frameClockGen.sv
module frameClockGen #(
  parameter int FRAME_LEN    = 768,
  parameter int MCLK_PER_BIT = 12,
  parameter int TOL_DIV      = 16,
  localparam int CNT_W = $clog2(FRAME_LEN)
) (
  input  logic             mclk,
  input  logic             rstN,
  input  logic             masterMode,
  input  logic             extLrclk,
  output logic             lrclkOut,
  output logic             bitclkOut,
  output logic [CNT_W-1:0] frameCount,
  output logic             resync
);
  fcgPkg::fcgStrobes_t strobes;

  fcgControl #(
    .FRAME_LEN  (FRAME_LEN),
    .TOL_DIV    (TOL_DIV),
    .SYNC_STAGES(2)
  ) uCtrl (
    .mclk      (mclk),
    .rstN      (rstN),
    .masterMode(masterMode),
    .extLrclk  (extLrclk),
    .countIn   (frameCount),
    .strobes   (strobes),
    .resyncQ   (resync)
  );

  fcgDatapath #(
    .FRAME_LEN   (FRAME_LEN),
    .MCLK_PER_BIT(MCLK_PER_BIT)
  ) uPath (
    .mclk     (mclk),
    .rstN     (rstN),
    .strobes  (strobes),
    .countQ   (frameCount),
    .lrclkOut (lrclkOut),
    .bitclkOut(bitclkOut)
  );

endmodule

// File: rtl/fcgChecker.sv
module fcgChecker #(
  parameter int FRAME_LEN = 768,
  localparam int CNT_W = $clog2(FRAME_LEN)
) (
  input logic             mclk,
  input logic             rstN,
  input logic             masterMode,
  input logic             lrclkOut,
  input logic             bitclkOut,
  input logic [CNT_W-1:0] frameCount,
  input logic             resync
);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(FRAME_LEN - 1);

  AST_RESET_QUIET: assert property (@(posedge mclk)
    !rstN |-> (!lrclkOut && !bitclkOut && !resync && frameCount == '0)); // R1

  AST_MASTER_STEP: assert property (@(posedge mclk) disable iff (!rstN)
    (masterMode && frameCount != LAST_CNT) |=> frameCount == $past(frameCount) + CNT_W'(1)); // R2

  AST_MASTER_WRAP: assert property (@(posedge mclk) disable iff (!rstN)
    (masterMode && frameCount == LAST_CNT) |=> frameCount == '0); // R2

  AST_MASTER_NO_RESYNC: assert property (@(posedge mclk) disable iff (!rstN)
    masterMode |-> !resync); // R4

  AST_SLAVE_QUIET: assert property (@(posedge mclk) disable iff (!rstN)
    !masterMode |-> (!lrclkOut && !bitclkOut)); // R5

  AST_RESYNC_ALIGN: assert property (@(posedge mclk) disable iff (!rstN)
    resync |-> frameCount == CNT_W'(1)); // R8

  AST_RESYNC_SINGLE: assert property (@(posedge mclk) disable iff (!rstN)
    resync |=> !resync); // R8

  AST_COUNT_RANGE: assert property (@(posedge mclk) disable iff (!rstN)
    frameCount <= LAST_CNT); // R2

endmodule

bind frameClockGen fcgChecker #(.FRAME_LEN(FRAME_LEN)) uChecker (
  .mclk      (mclk),
  .rstN      (rstN),
  .masterMode(masterMode),
  .lrclkOut  (lrclkOut),
  .bitclkOut (bitclkOut),
  .frameCount(frameCount),
  .resync    (resync)
);

// File: tb/tb_frameClockGen.sv
`timescale 1ns/1ps
module tb_frameClockGen;
  localparam int FRAME = 768;
  localparam int TOL   = 48;

  logic       mclk = 1'b0;
  logic       rstN = 1'b0;
  logic       masterMode = 1'b1;
  logic       extLrclk = 1'b0;
  logic       lrclkOut, bitclkOut, resync;
  logic [9:0] frameCount;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  frameClockGen dut (
    .mclk(mclk), .rstN(rstN), .masterMode(masterMode), .extLrclk(extLrclk),
    .lrclkOut(lrclkOut), .bitclkOut(bitclkOut), .frameCount(frameCount),
    .resync(resync)
  );

  always #2.5 mclk = ~mclk;

  typedef struct {
    int cnt;
    bit rs;
    string req;
  } expItem_t;

  expItem_t expQ[$];
  event sampleEv;

  int edgeBase = 0;
  int edgeGap  = 0;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // driver: raises the external frame clock, predicts the outcome
  task automatic frameEdge(input int period);
    int c;
    int e;
    bit rs;
    expItem_t it;
    c  = (edgeBase + edgeGap) % FRAME;
    e  = (c < FRAME / 2) ? c : c - FRAME;
    rs = (e > TOL) || (e < -TOL);
    it.cnt = rs ? 1 : (c + 1) % FRAME;
    it.rs  = rs;
    it.req = rs ? "R8" : ((edgeGap == 0) ? "R6" : "R7");
    expQ.push_back(it);
    extLrclk = 1'b1;
    -> sampleEv;
    repeat (period / 2) @(negedge mclk);
    extLrclk = 1'b0;
    repeat (period - period / 2) @(negedge mclk);
    edgeBase = rs ? 0 : c;
    edgeGap  = period;
  endtask

  // monitor: samples the result after the synchronizer latency
  initial begin
    forever begin
      expItem_t it;
      @(sampleEv);
      repeat (3) @(posedge mclk);
      @(negedge mclk);
      it = expQ.pop_front();
      check({it.req, " count"}, int'(frameCount), it.cnt);
      check({it.req, " resync"}, int'(resync), int'(it.rs));
    end
  end

  initial begin
    #900000;
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    // reset state, master role selected
    repeat (4) @(negedge mclk);
    check("R1 count", int'(frameCount), 0);
    check("R1 lrclk", int'(lrclkOut), 0);
    check("R1 bitclk", int'(bitclkOut), 0);
    check("R1 resync", int'(resync), 0);

    rstN = 1'b1;
    for (int n = 1; n <= 1700; n++) begin
      @(negedge mclk);
      if (n % 97 == 0) extLrclk = ~extLrclk; // R4 stimulus
      check("R2 count", int'(frameCount), n % FRAME);
      check("R3 lrclk", int'(lrclkOut), int'((n % FRAME) < FRAME / 2));
      check("R3 bitclk", int'(bitclkOut), int'((n % 12) >= 6));
      check("R4 resync", int'(resync), 0);
    end

    // slave role
    extLrclk = 1'b0;
    rstN = 1'b0;
    @(negedge mclk);
    masterMode = 1'b0;
    @(negedge mclk);
    rstN = 1'b1;
    for (int n = 0; n < 40; n++) begin
      @(negedge mclk);
      check("R5 hold", int'(frameCount), 0);
      check("R5 lrclk", int'(lrclkOut), 0);
      check("R5 bitclk", int'(bitclkOut), 0);
    end

    frameEdge(768); // first edge: aligned start
    frameEdge(816); // next error 0
    frameEdge(672); // next error +48
    frameEdge(865); // next error -48
    frameEdge(719); // next error +49 -> realign
    frameEdge(778); // next error -49 -> realign
    frameEdge(768); // next error +10
    frameEdge(400); // next error +10
    repeat (10) @(negedge mclk);
    check("R5 lrclk", int'(lrclkOut), 0);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule